// File: doc/BRIEF.md
# 1-Wire Bus Timing Master

This block produces standard-speed 1-Wire waveforms on one open-drain data line. It only pulls the line low or lets it go. An external pull-up resistor supplies the high level. A host issues one of four requests through a small command port: a bus reset with presence detection, an eight-bit write, an eight-bit read, or a single-bit exchange. The block answers each request with a one-cycle completion strobe. Where the request returns something, it also returns a presence flag or read data.

All slot timing is counted in whole microseconds. A clock-enable divider, set by the parameter `CLKS_PER_US`, derives one tick per microsecond from the system clock. The returned line passes through a two-flop synchronizer. Presence and read bits are not taken from a single strobe point. The line is sampled on every microsecond tick across a window, and one low sample is enough to decide the result. Every slot ends with fixed recovery time, so back-to-back slots never need extra spacing from the host.

Top module: `ow_master`

## Requirements
- R1: A reset request (cmd = 0) pulls the line low for 500 µs. The request then completes 1530 µs after acceptance: 500 µs low, 50 µs wait, 60 µs presence window and 920 µs recovery.
- R2: After a reset, presence reads 1 when the line is seen low on any 1 µs sample in the 60 µs window. The window opens 50 µs after the line is released.
- R3: After a reset, presence reads 0 when the line is low only before or after that window.
- R4: A write slot pulls the line low for 5 µs when sending a 1 and for 90 µs when sending a 0. The line is then released for at least 10 µs before the next slot begins.
- R5: A read slot pulls the line low for 3 µs, waits 10 µs, then samples once per µs for 40 µs. The bit is 0 if any sample is low. At least 75 µs of released line follow the 3 µs low before the next slot.
- R6: A write byte (cmd = 1) sends wdata[0] first and wdata[7] last. A read byte (cmd = 2) places the first slot's bit in rdata[0] and the eighth in rdata[7].
- R7: A single-bit request (cmd = 3) runs a read slot when wdata[0] = 1 and returns {7'b0, bit} on rdata. When wdata[0] = 0 it runs a write-0 slot and returns rdata = 0.
- R8: busy rises on the clock after a request is accepted and falls together with done. A request made while busy is high is ignored: no slot, no done, no change of presence or rdata.
- R9: done is a single-cycle pulse. presence changes only on completion of a reset, and rdata only on completion of a read byte or single-bit request. Both hold until then.
- R10: After reset the line is released, busy and done are 0, presence is 0 and rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when busy is low |
| cmd | input | 2 | 0 reset, 1 write byte, 2 read byte, 3 single bit |
| wdata | input | BYTE_W | Byte to write, or bit 0 for a single-bit request |
| ow_in | input | 1 | Sensed level of the bus line |
| ow_drive_low | output | 1 | 1 pulls the bus line low, 0 releases it |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| presence | output | 1 | Presence seen during the last reset |
| rdata | output | BYTE_W | Result of the last read byte or single-bit request |

## Verification
The hardest cases to reach are the edges of the sampling windows. A device pull that just overlaps the last microsecond samples must count. A pull that ends before the first sample, or starts after the last one, must not count. From the ports these differ only in the position of a short low pulse, measured against the master's own falling edge. The bench's device model restarts a cycle counter on every falling edge of the line. It pulls the line low over a programmable span of that counter, per slot, for each slot whose scripted bit is 0. This places pulses inside, just inside, and just outside both the read and the presence windows.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    CMD_RESET  = 2'd0,
    CMD_WRBYTE = 2'd1,
    CMD_RDBYTE = 2'd2,
    CMD_BIT    = 2'd3
  } ow_cmd_e;

  typedef enum logic [1:0] {
    SLOT_RST = 2'd0,
    SLOT_WR  = 2'd1,
    SLOT_RD  = 2'd2
  } slot_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HOLD,
    PH_SAMPLE,
    PH_RECOV
  } phase_e;

  // durations in microseconds
  localparam int unsigned T_RST_LOW   = 500;
  localparam int unsigned T_RST_WAIT  = 50;
  localparam int unsigned T_RST_WIN   = 60;
  localparam int unsigned T_RST_RECOV = 920;
  localparam int unsigned T_WR_LOW    = 5;
  localparam int unsigned T_WR_HOLD   = 85;
  localparam int unsigned T_WR_RECOV  = 10;
  localparam int unsigned T_RD_LOW    = 3;
  localparam int unsigned T_RD_WAIT   = 10;
  localparam int unsigned T_RD_WIN    = 40;
  localparam int unsigned T_RD_RECOV  = 25;

  localparam int unsigned US_CNT_W = $clog2(T_RST_RECOV + 1);

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int unsigned CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ow_sync2.sv
module ow_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  slot_kind_e kind,
  input  logic       wbit,
  input  logic       line_s,
  output logic       line_low,
  output logic       done,
  output logic       result
);

  phase_e               phase;
  slot_kind_e           kind_q;
  logic                 wbit_q;
  logic [US_CNT_W-1:0]  remain;

  function automatic logic [US_CNT_W-1:0] ph_len(slot_kind_e k, phase_e p);
    int unsigned v;
    v = 0;
    case (p)
      PH_LOW:    v = (k == SLOT_RST) ? T_RST_LOW   : (k == SLOT_WR) ? T_WR_LOW   : T_RD_LOW;
      PH_HOLD:   v = (k == SLOT_RST) ? T_RST_WAIT  : (k == SLOT_WR) ? T_WR_HOLD  : T_RD_WAIT;
      PH_SAMPLE: v = (k == SLOT_RST) ? T_RST_WIN   : (k == SLOT_WR) ? 0          : T_RD_WIN;
      PH_RECOV:  v = (k == SLOT_RST) ? T_RST_RECOV : (k == SLOT_WR) ? T_WR_RECOV : T_RD_RECOV;
      default:   v = 0;
    endcase
    return US_CNT_W'(v);
  endfunction

  function automatic phase_e ph_next(slot_kind_e k, phase_e p);
    case (p)
      PH_LOW:    return PH_HOLD;
      PH_HOLD:   return (ph_len(k, PH_SAMPLE) != '0) ? PH_SAMPLE : PH_RECOV;
      PH_SAMPLE: return PH_RECOV;
      default:   return PH_IDLE;
    endcase
  endfunction

  phase_e nxt;
  assign nxt = ph_next(kind_q, phase);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      phase    <= PH_IDLE;
      kind_q   <= SLOT_RST;
      wbit_q   <= 1'b1;
      remain   <= '0;
      line_low <= 1'b0;
      result   <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase    <= PH_LOW;
        kind_q   <= kind;
        wbit_q   <= wbit;
        remain   <= ph_len(kind, PH_LOW);
        line_low <= 1'b1;
        result   <= (kind == SLOT_RST) ? 1'b0 : (kind == SLOT_RD) ? 1'b1 : wbit;
      end
    end else if (tick) begin
      // any low sample in the window decides the result
      if (phase == PH_SAMPLE && !line_s) result <= (kind_q == SLOT_RST);
      if (remain == US_CNT_W'(1)) begin
        phase    <= nxt;
        remain   <= ph_len(kind_q, nxt);
        line_low <= (nxt == PH_HOLD) && (kind_q == SLOT_WR) && !wbit_q;
        if (nxt == PH_IDLE) done <= 1'b1;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 125,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        cmd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ow_in,
  output logic              ow_drive_low,
  output logic              busy,
  output logic              done,
  output logic              presence,
  output logic [BYTE_W-1:0] rdata
);
  localparam int unsigned BC_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  ow_cmd_e           cmd_q;
  logic [BYTE_W-1:0] sh;
  logic [BC_W-1:0]   bit_cnt;

  logic       tick, line_s, eng_done, eng_res, eng_start, accept, last_slot;
  slot_kind_e eng_kind;
  logic       eng_wbit;
  logic [BYTE_W-1:0] next_sh;

  assign accept    = req && !busy;
  assign last_slot = (cmd_q == CMD_RESET) || (cmd_q == CMD_BIT) || (bit_cnt == BC_LAST);
  assign eng_start = accept || (busy && eng_done && !last_slot);

  always_comb begin
    case (cmd_q)
      CMD_WRBYTE: next_sh = sh >> 1;
      CMD_RDBYTE: next_sh = {eng_res, sh[BYTE_W-1:1]};
      default:    next_sh = sh;
    endcase
  end

  always_comb begin
    if (!busy) begin
      case (ow_cmd_e'(cmd))
        CMD_RESET:  eng_kind = SLOT_RST;
        CMD_WRBYTE: eng_kind = SLOT_WR;
        CMD_RDBYTE: eng_kind = SLOT_RD;
        default:    eng_kind = wdata[0] ? SLOT_RD : SLOT_WR;
      endcase
      eng_wbit = wdata[0];
    end else begin
      eng_kind = (cmd_q == CMD_WRBYTE) ? SLOT_WR : SLOT_RD;
      eng_wbit = next_sh[0];
    end
  end

  ow_us_tick #(.CLKS_PER_US(CLKS_PER_US)) tick_i (
    .clk(clk), .rst(rst), .clr(eng_start), .tick(tick)
  );

  ow_sync2 #(.RESET_VAL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d(ow_in), .q(line_s)
  );

  ow_slot_engine eng_i (
    .clk(clk), .rst(rst), .tick(tick), .start(eng_start),
    .kind(eng_kind), .wbit(eng_wbit), .line_s(line_s),
    .line_low(ow_drive_low), .done(eng_done), .result(eng_res)
  );

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy     <= 1'b0;
      presence <= 1'b0;
      rdata    <= '0;
      cmd_q    <= CMD_RESET;
      sh       <= '0;
      bit_cnt  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cmd_q   <= ow_cmd_e'(cmd);
      sh      <= wdata;
      bit_cnt <= '0;
    end else if (busy && eng_done) begin
      sh      <= next_sh;
      bit_cnt <= bit_cnt + 1'b1;
      if (last_slot) begin
        busy <= 1'b0;
        done <= 1'b1;
        case (cmd_q)
          CMD_RESET:  presence <= eng_res;
          CMD_RDBYTE: rdata    <= next_sh;
          CMD_BIT:    rdata    <= {{(BYTE_W-1){1'b0}}, eng_res};
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              busy,
  input logic              done,
  input logic              presence,
  input logic [BYTE_W-1:0] rdata,
  input logic              ow_drive_low
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ow_drive_low);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));

  assert_presence_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(presence));
endmodule

bind ow_master ow_master_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .done(done),
  .presence(presence), .rdata(rdata), .ow_drive_low(ow_drive_low)
);

// File: tb/ow_master_tb_top.sv
module ow_master_tb_top;
  localparam int CPU = 2;  // clocks per microsecond for a short run

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire        ow_in;
  logic       drv, busy, done, presence;
  logic [7:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  // device model and line monitor
  logic [7:0] sbits = 8'hFF;
  int   lo_s = 0, lo_e = 0;      // pull span in cycles after each fall
  logic mon_clr = 1'b0;
  int   fall_cnt = 0, slot_idx = 0, low_cnt = 0, last_low = 0;
  int   high_cnt = 0, last_gap = 0;
  logic cur_bit = 1'b1, prev_drv = 1'b0;
  logic [7:0] obs = 8'd0;
  logic slave_low;

  assign slave_low = (slot_idx > 0) && !cur_bit && (fall_cnt >= lo_s) && (fall_cnt < lo_e);
  assign ow_in = !(drv || slave_low);

  always @(negedge clk) begin
    prev_drv <= drv;
    if (mon_clr) begin
      slot_idx <= 0; fall_cnt <= 0; cur_bit <= 1'b1;
      low_cnt <= 0; high_cnt <= 0; obs <= 8'd0;
    end else begin
      fall_cnt <= fall_cnt + 1;
      if (drv && !prev_drv) begin
        fall_cnt <= 1;
        cur_bit  <= sbits[slot_idx[2:0]];
        slot_idx <= slot_idx + 1;
        low_cnt  <= 1;
        last_gap <= high_cnt;
      end else if (drv) begin
        low_cnt <= low_cnt + 1;
      end else if (prev_drv) begin
        last_low <= low_cnt;
        obs      <= {(low_cnt <= 14), obs[7:1]};
        high_cnt <= 1;
      end else begin
        high_cnt <= high_cnt + 1;
      end
    end
  end

  ow_master #(.CLKS_PER_US(CPU), .BYTE_W(8)) dut_i (
    .clk(clk), .rst(rst), .req(req), .cmd(cmd), .wdata(wdata),
    .ow_in(ow_in), .ow_drive_low(drv), .busy(busy), .done(done),
    .presence(presence), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // issue a request and wait for done; dur = edges from acceptance to done
  task automatic run_op(input logic [1:0] c, input logic [7:0] w, output int dur);
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
    req = 1'b1; cmd = c; wdata = w;
    @(posedge clk); #1 req = 1'b0;
    dur = 1;
    while (!done && dur < 20000) begin
      @(posedge clk); #1 dur++;
    end
  endtask

  typedef struct packed {
    logic [1:0]  c;
    logic [7:0]  w;
    logic [7:0]  sb;
    logic [15:0] ls;   // µs
    logic [15:0] le;   // µs
    logic [7:0]  ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h00, 8'hFE, 16'd560, 16'd600, 8'h01, 4'd2},  // R2 pull inside window
    '{2'd0, 8'h00, 8'hFE, 16'd615, 16'd650, 8'h00, 4'd3},  // R3 pull after window
    '{2'd0, 8'h00, 8'hFE, 16'd530, 16'd545, 8'h00, 4'd3},  // R3 pull before window
    '{2'd1, 8'hA5, 8'hFF, 16'd0,   16'd0,   8'hA5, 4'd6},  // R6 write LSB first
    '{2'd1, 8'h3C, 8'hFF, 16'd0,   16'd0,   8'h3C, 4'd4},  // R4 write pattern
    '{2'd2, 8'h00, 8'hA5, 16'd20,  16'd40,  8'hA5, 4'd6},  // R6 read LSB first
    '{2'd2, 8'h00, 8'h00, 16'd50,  16'd52,  8'h00, 4'd5},  // R5 pull at window tail
    '{2'd2, 8'h00, 8'h00, 16'd56,  16'd70,  8'hFF, 4'd5},  // R5 pull after window
    '{2'd2, 8'h00, 8'h00, 16'd4,   16'd10,  8'hFF, 4'd5},  // R5 pull before window
    '{2'd3, 8'h01, 8'hFE, 16'd20,  16'd40,  8'h00, 4'd7},  // R7 read slot sees 0
    '{2'd3, 8'h01, 8'hFF, 16'd20,  16'd40,  8'h01, 4'd7},  // R7 read slot sees 1
    '{2'd3, 8'h00, 8'hFF, 16'd0,   16'd0,   8'h00, 4'd7}   // R7 write-0 slot
  };

  initial begin
    int dur;
    logic [7:0] rd_keep;
    logic pr_keep;
    int s_before;

    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0,     "R10 busy", busy, 0);
    chk(done == 0,     "R10 done", done, 0);
    chk(drv == 0,      "R10 line", drv, 0);
    chk(presence == 0, "R10 presence", presence, 0);
    chk(rdata == 0,    "R10 rdata", rdata, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      sbits = VECS[i].sb;
      lo_s  = int'(VECS[i].ls) * CPU;
      lo_e  = int'(VECS[i].le) * CPU;
      run_op(VECS[i].c, VECS[i].w, dur);
      chk(done == 1, $sformatf("R%0d done vec%0d", VECS[i].rq, i), done, 1);
      case (VECS[i].c)
        2'd0: chk(presence == VECS[i].ex[0], $sformatf("R%0d presence vec%0d", VECS[i].rq, i),
                  presence, VECS[i].ex[0]);
        2'd1: begin
          @(negedge clk);
          chk(obs == VECS[i].ex, $sformatf("R%0d written bits vec%0d", VECS[i].rq, i),
              obs, VECS[i].ex);
        end
        default: chk(rdata == VECS[i].ex, $sformatf("R%0d rdata vec%0d", VECS[i].rq, i),
                     rdata, VECS[i].ex);
      endcase
      if (VECS[i].c == 2'd3 && VECS[i].w[0] == 1'b0) begin
        @(negedge clk);
        chk(last_low == 90 * CPU, "R7 write-0 low width", last_low, 90 * CPU);
      end
    end

    // R1 reset pulse width and total duration
    sbits = 8'hFF; lo_s = 0; lo_e = 0;
    run_op(2'd0, 8'h00, dur);
    chk(last_low >= 500 * CPU && last_low <= 500 * CPU + 1, "R1 reset low width", last_low, 500 * CPU);
    chk(dur >= 1530 * CPU && dur <= 1530 * CPU + 2, "R1 reset duration", dur, 1530 * CPU + 1);
    chk(presence == 0, "R3 no device", presence, 0);

    // R4 write-1 width, write-0 recovery gap
    run_op(2'd3, 8'h00, dur);
    run_op(2'd1, 8'hFF, dur);
    @(negedge clk);
    chk(last_low >= 5 * CPU && last_low <= 5 * CPU + 1, "R4 write-1 low width", last_low, 5 * CPU);
    run_op(2'd1, 8'h00, dur);
    @(negedge clk);
    chk(last_gap >= 10 * CPU && last_gap <= 10 * CPU + 2, "R4 recovery gap", last_gap, 10 * CPU + 1);

    // R5 read low width and inter-slot spacing
    run_op(2'd2, 8'h00, dur);
    @(negedge clk);
    chk(last_low >= 3 * CPU && last_low <= 3 * CPU + 1, "R5 read low width", last_low, 3 * CPU);
    chk(last_gap >= 75 * CPU && last_gap <= 75 * CPU + 2, "R5 read spacing", last_gap, 75 * CPU + 1);
    chk(rdata == 8'hFF, "R5 released reads ones", rdata, 8'hFF);

    // R9 done is one cycle, results hold
    rd_keep = rdata;
    @(posedge clk); #1;
    chk(done == 0, "R9 done single pulse", done, 0);
    repeat (50) @(posedge clk);
    #1 chk(rdata == rd_keep, "R9 rdata holds", rdata, rd_keep);

    // R8 busy during operation, request while busy ignored
    sbits = 8'h00; lo_s = 20 * CPU; lo_e = 40 * CPU;
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0; req = 1'b1; cmd = 2'd2;
    @(posedge clk); #1 req = 1'b0;
    chk(busy == 1, "R8 busy after accept", busy, 1);
    pr_keep = presence;
    repeat (20) @(posedge clk);
    #1 req = 1'b1; cmd = 2'd0;
    @(posedge clk); #1 req = 1'b0;
    dur = 0;
    while (!done && dur < 20000) begin @(posedge clk); #1 dur++; end
    chk(rdata == 8'h00, "R8 read unaffected", rdata, 8'h00);
    chk(busy == 0, "R8 busy falls with done", busy, 0);
    @(negedge clk) s_before = slot_idx;
    repeat (3500) @(posedge clk);
    @(negedge clk);
    chk(slot_idx == s_before, "R8 ignored request made no slot", slot_idx, s_before);
    chk(presence == pr_keep, "R8 presence unchanged", presence, pr_keep);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule